// File: doc/BRIEF.md
# Shared Transfer Buffer Access Arbiter

This block lets two requesters share one single-port 1024 x 32-bit transfer buffer. An embedded processor asks for the buffer with a request line held high while it issues its reads and writes. An external host does not have a request wire. Instead it sets a request flag by writing a 1 into a request register on a small register port. After it is granted, it moves data on a transfer port and ends its turn with a done pulse.

A priority bit decides which side wins when both sides are requesting in the cycle the arbiter decides. A grant is kept until its owner lets go, and a request from the other side never preempts it. The block drives the buffer's address, write data and write enable from the owning side only. The buffer's read data goes back to both sides, and only the owner gets a read-valid flag. A saturating counter tracks how many words have been written since it was last cleared. It never goes above its limit, which is 2048 by default.

Top module: `buf_arbiter`

## Requirements
- R1: After a synchronous active-low reset, neither grant is asserted, the host request flag is 0, the priority bit is 0, the valid count is 0 and the buffer write enable is 0.
- R2: A host register write to address 0xA with the data bit at 1 sets the host request flag on that clock edge. The same write with the data bit at 0 leaves the flag unchanged.
- R3: A host register write to address 0x2 loads the priority bit from the data bit. When the processor request and the host request flag are both high in a cycle with no owner, the grant goes to the processor if the priority bit is 0 and to the host if it is 1. The grant is visible from the following clock edge.
- R4: A grant is held while its owner still requests: while the processor request stays high, or until the host pulses done. A request from the other side never takes the grant away.
- R5: At most one of the two grants is asserted in any cycle.
- R6: The buffer address, write data and write enable come from the owning side only. A write attempted by the side that does not own the buffer does not reach the buffer.
- R7: When no side owns the buffer, the buffer write enable is 0.
- R8: A done pulse while the host owns the buffer clears the host request flag and releases the grant on the same edge. On that edge the arbiter decides again among the requests that remain.
- R9: A read by the owner in one cycle raises that side's read-valid flag in the next cycle, and the other side's flag stays low. The buffer read data is passed to the shared read-data output at all times.
- R10: The valid count rises by one for each buffer write and stops at 2048. A host register write to address 0x3 clears the count, and the clear takes precedence over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor requests the buffer |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 10 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_gnt | output | 1 | Processor owns the buffer |
| cpu_rvalid | output | 1 | Read data valid for the processor |
| hreg_wr | input | 1 | Host register write strobe |
| hreg_addr | input | 4 | Host register address |
| hreg_bit | input | 1 | Host register write data bit |
| hx_valid | input | 1 | Host transfer beat present |
| hx_we | input | 1 | Host transfer beat is a write |
| hx_addr | input | 10 | Host transfer word address |
| hx_wdata | input | 32 | Host transfer write data |
| hx_done | input | 1 | Host ends its transfer |
| host_gnt | output | 1 | Host owns the buffer |
| host_rvalid | output | 1 | Read data valid for the host |
| host_pend | output | 1 | Host request flag |
| host_first | output | 1 | Priority bit (1 means the host wins a tie) |
| buf_addr | output | 10 | Buffer address |
| buf_wdata | output | 32 | Buffer write data |
| buf_we | output | 1 | Buffer write enable |
| buf_rdata | input | 32 | Buffer read data |
| rd_data | output | 32 | Shared read data to both sides |
| valid_count | output | 12 | Saturating count of words written |

## Verification
The hardest case to reach is a real tie. The host flag is registered, so the processor has to raise its request in exactly the cycle after the host's register write, while the arbiter has no owner. The directed part of the stimulus times this on purpose with each value of the priority bit. It also runs a release that hands the grant straight to a waiting host, and more than 2048 back-to-back writes to reach count saturation. Random traffic then mixes register writes, done pulses and requests from both sides, and a cycle-level reference model in the bench checks every output.

// File: rtl/buf_arb_pkg.sv
// Package: shared owner type and tie-break function for the buffer arbiter.
// Assumes two requesters only; a value outside the enum never occurs.
package buf_arb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_HOST = 2'd2
    } own_t;

    // Choose an owner among the live requests; host_first breaks a tie.
    function automatic own_t pick_owner(input logic c, input logic h, input logic host_first);
        if (c && h)  return host_first ? OWN_HOST : OWN_CPU;
        else if (c)  return OWN_CPU;
        else if (h)  return OWN_HOST;
        else         return OWN_NONE;
    endfunction

endpackage

// File: rtl/buf_arb_host_regs.sv
// Host register file: request flag, priority bit and count-clear strobe.
// Assumes one register write per cycle. A done pulse counts only while
// the host owns the buffer, and it wins over a request write in the same cycle.
module buf_arb_host_regs #(
    parameter int RAW       = 4,
    parameter int REQ_ADDR  = 4'hA,
    parameter int PRIO_ADDR = 4'h2,
    parameter int CLR_ADDR  = 4'h3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hreg_wr,
    input  logic [RAW-1:0] hreg_addr,
    input  logic           hreg_bit,
    input  logic           host_owns,
    input  logic           hx_done,
    output logic           host_pend,
    output logic           host_first,
    output logic           count_clr
);
    logic req_hit, prio_hit;

    // Address decode of the three host registers.
    always_comb begin
        req_hit   = hreg_wr && (hreg_addr == RAW'(REQ_ADDR));
        prio_hit  = hreg_wr && (hreg_addr == RAW'(PRIO_ADDR));
        count_clr = hreg_wr && (hreg_addr == RAW'(CLR_ADDR));
    end

    // Request flag: set by a write of 1, cleared when the owned transfer ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                    host_pend <= 1'b0;
        else if (host_owns && hx_done) host_pend <= 1'b0;
        else if (req_hit && hreg_bit)  host_pend <= 1'b1;
    end

    // Priority bit: loaded from the data bit on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)        host_first <= 1'b0;
        else if (prio_hit) host_first <= hreg_bit;
    end

endmodule

// File: rtl/buf_arb_fsm.sv
// Ownership state machine. It holds the owner until that side releases,
// then decides again in the same cycle among the requests still live.
// Assumes host_pend is the registered request flag from the register file.
module buf_arb_fsm
    import buf_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic host_pend,
    input  logic hx_done,
    input  logic host_first,
    output own_t owner
);
    own_t owner_nxt;

    // Next owner: keep it while the owner still holds on, otherwise decide again.
    always_comb begin
        unique case (owner)
            OWN_CPU:  owner_nxt = cpu_req ? OWN_CPU : pick_owner(1'b0, host_pend, host_first);
            OWN_HOST: owner_nxt = !hx_done ? OWN_HOST : pick_owner(cpu_req, 1'b0, host_first);
            default:  owner_nxt = pick_owner(cpu_req, host_pend, host_first);
        endcase
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) owner <= OWN_NONE;
        else        owner <= owner_nxt;
    end

endmodule

// File: rtl/buf_arb_path.sv
// Buffer data path: steers the owner's access onto the buffer, returns
// read data with a per-side valid flag one cycle later, and counts writes
// up to a saturation limit. Assumes the buffer reads synchronously (one cycle).
module buf_arb_path
    import buf_arb_pkg::*;
#(
    parameter int AW   = 10,
    parameter int DW   = 32,
    parameter int CMAX = 2048,
    localparam int CW  = $clog2(CMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  own_t          owner,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          hx_valid,
    input  logic          hx_we,
    input  logic [AW-1:0] hx_addr,
    input  logic [DW-1:0] hx_wdata,
    input  logic          count_clr,
    input  logic [DW-1:0] buf_rdata,
    output logic [AW-1:0] buf_addr,
    output logic [DW-1:0] buf_wdata,
    output logic          buf_we,
    output logic [DW-1:0] rd_data,
    output logic          cpu_rvalid,
    output logic          host_rvalid,
    output logic [CW-1:0] valid_count
);
    logic cpu_rd, host_rd;

    // Steer the buffer from the current owner; no owner means no write.
    always_comb begin
        buf_addr  = '0;
        buf_wdata = '0;
        buf_we    = 1'b0;
        cpu_rd    = 1'b0;
        host_rd   = 1'b0;
        unique case (owner)
            OWN_CPU: begin
                buf_addr  = cpu_addr;
                buf_wdata = cpu_wdata;
                buf_we    = cpu_req && cpu_we;
                cpu_rd    = cpu_req && !cpu_we;
            end
            OWN_HOST: begin
                buf_addr  = hx_addr;
                buf_wdata = hx_wdata;
                buf_we    = hx_valid && hx_we;
                host_rd   = hx_valid && !hx_we;
            end
            default: ;
        endcase
        rd_data = buf_rdata;
    end

    // Read-valid flags follow the owner's read by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid  <= 1'b0;
            host_rvalid <= 1'b0;
        end else begin
            cpu_rvalid  <= cpu_rd;
            host_rvalid <= host_rd;
        end
    end

    // Saturating write counter; a clear wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n || count_clr)                   valid_count <= '0;
        else if (buf_we && valid_count < CW'(CMAX)) valid_count <= valid_count + 1'b1;
    end

endmodule

// File: rtl/buf_arbiter.sv
// Top: arbitrates a shared transfer buffer between a processor port and a
// host that requests through a register write. Assumes a single clock
// domain and a synchronous active-low reset.
module buf_arbiter
    import buf_arb_pkg::*;
#(
    parameter int AW   = 10,
    parameter int DW   = 32,
    parameter int CMAX = 2048,
    localparam int CW  = $clog2(CMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    output logic          cpu_rvalid,
    input  logic          hreg_wr,
    input  logic [3:0]    hreg_addr,
    input  logic          hreg_bit,
    input  logic          hx_valid,
    input  logic          hx_we,
    input  logic [AW-1:0] hx_addr,
    input  logic [DW-1:0] hx_wdata,
    input  logic          hx_done,
    output logic          host_gnt,
    output logic          host_rvalid,
    output logic          host_pend,
    output logic          host_first,
    output logic [AW-1:0] buf_addr,
    output logic [DW-1:0] buf_wdata,
    output logic          buf_we,
    input  logic [DW-1:0] buf_rdata,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] valid_count
);
    own_t owner;
    logic count_clr;

    // Grant outputs decoded from the owner register.
    always_comb begin
        cpu_gnt  = (owner == OWN_CPU);
        host_gnt = (owner == OWN_HOST);
    end

    buf_arb_host_regs #(.RAW(4)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hreg_wr(hreg_wr), .hreg_addr(hreg_addr), .hreg_bit(hreg_bit),
        .host_owns(host_gnt), .hx_done(hx_done),
        .host_pend(host_pend), .host_first(host_first), .count_clr(count_clr)
    );

    buf_arb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .host_pend(host_pend), .hx_done(hx_done),
        .host_first(host_first), .owner(owner)
    );

    buf_arb_path #(.AW(AW), .DW(DW), .CMAX(CMAX)) u_path (
        .clk(clk), .rst_n(rst_n), .owner(owner),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .hx_valid(hx_valid), .hx_we(hx_we), .hx_addr(hx_addr), .hx_wdata(hx_wdata),
        .count_clr(count_clr), .buf_rdata(buf_rdata),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we), .rd_data(rd_data),
        .cpu_rvalid(cpu_rvalid), .host_rvalid(host_rvalid), .valid_count(valid_count)
    );

endmodule

// File: rtl/buf_arbiter_chk.sv
// Checker for buf_arbiter, attached by bind. It only watches ports.
module buf_arbiter_chk #(
    parameter int AW   = 10,
    parameter int CMAX = 2048,
    localparam int CW  = $clog2(CMAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic          cpu_gnt,
    input logic          cpu_rvalid,
    input logic          hx_valid,
    input logic          hx_we,
    input logic [AW-1:0] hx_addr,
    input logic          hx_done,
    input logic          host_gnt,
    input logic          host_rvalid,
    input logic          host_pend,
    input logic [AW-1:0] buf_addr,
    input logic          buf_we,
    input logic [CW-1:0] valid_count
);
    assert_one_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, host_gnt}));

    assert_idle_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_gnt && !host_gnt) |-> !buf_we);

    assert_cpu_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && cpu_req) |=> cpu_gnt);

    assert_host_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && !hx_done) |=> host_gnt);

    assert_host_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && hx_done) |=> (!host_gnt && !host_pend));

    assert_host_steer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> (buf_addr == hx_addr && buf_we == (hx_valid && hx_we)));

    assert_cpu_steer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && buf_we) |-> (cpu_req && cpu_we));

    assert_cpu_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && cpu_req && !cpu_we) |=> (cpu_rvalid && !host_rvalid));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_count <= CW'(CMAX));

endmodule

bind buf_arbiter buf_arbiter_chk #(.AW(AW), .CMAX(CMAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_gnt(cpu_gnt), .cpu_rvalid(cpu_rvalid), .hx_valid(hx_valid),
    .hx_we(hx_we), .hx_addr(hx_addr), .hx_done(hx_done), .host_gnt(host_gnt),
    .host_rvalid(host_rvalid), .host_pend(host_pend), .buf_addr(buf_addr),
    .buf_we(buf_we), .valid_count(valid_count)
);

// File: tb/sim_buf_arbiter.sv
// Bench for buf_arbiter: directed corner cases plus seeded random traffic,
// each cycle compared against a reference model built from the requirements.
module sim_buf_arbiter;
    localparam int AW = 10, DW = 32, CMAX = 2048, CW = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0, hreg_wr = 0, hreg_bit = 0;
    logic hx_valid = 0, hx_we = 0, hx_done = 0;
    logic [AW-1:0] cpu_addr = '0, hx_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, hx_wdata = '0, buf_rdata = '0;
    logic [3:0] hreg_addr = '0;
    logic cpu_gnt, cpu_rvalid, host_gnt, host_rvalid, host_pend, host_first, buf_we;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_wdata, rd_data;
    logic [CW-1:0] valid_count;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    buf_arbiter u0 (.*);

    // Reference model: 0 none, 1 processor, 2 host
    int m_own = 0;
    bit m_pend = 0, m_prio = 0, m_crv = 0, m_hrv = 0;
    int m_cnt = 0;

    function automatic int pick(bit c, bit h, bit hf);
        if (c && h) return hf ? 2 : 1;
        if (c) return 1;
        if (h) return 2;
        return 0;
    endfunction

    function automatic bit exp_we(int own);
        return (own == 1 && cpu_req && cpu_we) || (own == 2 && hx_valid && hx_we);
    endfunction

    always @(posedge clk) begin
        int nown; bit done_ok, w;
        if (!rst_n) begin
            m_own = 0; m_pend = 0; m_prio = 0; m_crv = 0; m_hrv = 0; m_cnt = 0;
        end else begin
            done_ok = (m_own == 2) && hx_done;
            w = exp_we(m_own);
            if (m_own == 1)      nown = cpu_req ? 1 : pick(0, m_pend, m_prio);
            else if (m_own == 2) nown = !hx_done ? 2 : pick(cpu_req, 0, m_prio);
            else                 nown = pick(cpu_req, m_pend, m_prio);
            m_crv = (m_own == 1) && cpu_req && !cpu_we;
            m_hrv = (m_own == 2) && hx_valid && !hx_we;
            if (done_ok) m_pend = 0;
            else if (hreg_wr && hreg_addr == 4'hA && hreg_bit) m_pend = 1;
            if (hreg_wr && hreg_addr == 4'h2) m_prio = hreg_bit;
            if (hreg_wr && hreg_addr == 4'h3) m_cnt = 0;
            else if (w && m_cnt < CMAX) m_cnt++;
            m_own = nown;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R5 cpu_gnt", 32'(cpu_gnt), 32'(m_own == 1));
        chk("R4 host_gnt", 32'(host_gnt), 32'(m_own == 2));
        chk("R2 host_pend", 32'(host_pend), 32'(m_pend));
        chk("R3 host_first", 32'(host_first), 32'(m_prio));
        chk("R6 buf_we", 32'(buf_we), 32'(exp_we(m_own)));
        if (m_own == 2) chk("R6 buf_addr", 32'(buf_addr), 32'(hx_addr));
        if (m_own == 1) chk("R6 buf_wdata", buf_wdata, cpu_wdata);
        chk("R9 cpu_rvalid", 32'(cpu_rvalid), 32'(m_crv));
        chk("R9 host_rvalid", 32'(host_rvalid), 32'(m_hrv));
        chk("R9 rd_data", rd_data, buf_rdata);
        chk("R10 valid_count", 32'(valid_count), 32'(m_cnt));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic hreg(logic [3:0] a, logic b);
        hreg_wr = 1; hreg_addr = a; hreg_bit = b;
        cyc();
        hreg_wr = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 cpu_gnt", 32'(cpu_gnt), 0);
        chk("R1 host_gnt", 32'(host_gnt), 0);
        chk("R1 host_pend", 32'(host_pend), 0);
        chk("R1 host_first", 32'(host_first), 0);
        chk("R1 count", 32'(valid_count), 0);
        chk("R1 buf_we", 32'(buf_we), 0);

        // R2: writing 0 has no effect, writing 1 sets the flag
        hreg(4'hA, 0);
        chk("R2 write0 no effect", 32'(host_pend), 0);
        hreg(4'hA, 1);
        chk("R2 flag set", 32'(host_pend), 1);
        chk("R2 no grant yet", 32'(host_gnt), 0);
        cyc();
        chk("R2 host granted", 32'(host_gnt), 1);

        // R6: host owns; processor write is shut out
        hx_valid = 1; hx_we = 1; hx_addr = 10'd5; hx_wdata = 32'hCAFE0005;
        cpu_req = 1; cpu_we = 1; cpu_addr = 10'd9; cpu_wdata = 32'h9;
        #1;
        chk("R6 host addr", 32'(buf_addr), 5);
        chk("R6 host data", buf_wdata, 32'hCAFE0005);
        cyc();
        chk("R4 no preempt", 32'(host_gnt), 1);
        chk("R10 count one", 32'(valid_count), 1);

        // R8: done releases, processor takes over on the same edge
        hx_done = 1; hx_valid = 0;
        cyc();
        hx_done = 0;
        chk("R8 host released", 32'(host_gnt), 0);
        chk("R8 flag cleared", 32'(host_pend), 0);
        chk("R8 cpu granted", 32'(cpu_gnt), 1);

        // R9: processor read
        cpu_we = 0; buf_rdata = 32'h1234_5678;
        cyc();
        chk("R9 cpu valid", 32'(cpu_rvalid), 1);
        chk("R9 host not valid", 32'(host_rvalid), 0);
        chk("R9 shared data", rd_data, 32'h1234_5678);

        // R7: no owner, a write attempt does nothing
        cpu_req = 0;
        cyc();
        cpu_we = 1;
        #1;
        chk("R7 idle no write", 32'(buf_we), 0);

        // R3: tie with the priority bit at 1 goes to the host
        hreg(4'h2, 1);
        hreg_wr = 1; hreg_addr = 4'hA; hreg_bit = 1;
        cyc();
        hreg_wr = 0; cpu_req = 1;
        cyc();
        chk("R3 tie host wins", 32'(host_gnt), 1);
        hx_done = 1;
        cyc();
        hx_done = 0;
        chk("R8 handoff to cpu", 32'(cpu_gnt), 1);
        cpu_req = 0;
        cyc();

        // R3: tie with the priority bit at 0 goes to the processor
        hreg(4'h2, 0);
        hreg_wr = 1; hreg_addr = 4'hA; hreg_bit = 1;
        cyc();
        hreg_wr = 0; cpu_req = 1;
        cyc();
        chk("R3 tie cpu wins", 32'(cpu_gnt), 1);
        chk("R3 host waits", 32'(host_pend), 1);
        cyc();
        chk("R4 cpu held", 32'(cpu_gnt), 1);
        cpu_req = 0;
        cyc();
        chk("R4 waiting host gets grant", 32'(host_gnt), 1);
        hx_done = 1;
        cyc();
        hx_done = 0;

        // R10: saturation, then clear wins over a write
        hreg(4'h3, 0);
        cpu_req = 1; cpu_we = 1;
        repeat (CMAX + 3) cyc();
        chk("R10 saturated", 32'(valid_count), CMAX);
        hreg(4'h3, 0);
        chk("R10 cleared", 32'(valid_count), 0);
        cpu_req = 0;
        cyc();

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            cpu_req   = ($urandom % 4) != 0 ? cpu_req ^ (($urandom % 5) == 0) : 0;
            cpu_we    = $urandom % 2;
            cpu_addr  = AW'($urandom);
            cpu_wdata = $urandom;
            hreg_wr   = ($urandom % 6) == 0;
            hreg_addr = ($urandom % 3 == 0) ? 4'h2 : (($urandom % 4 == 0) ? 4'h3 : 4'hA);
            hreg_bit  = $urandom % 2;
            hx_valid  = $urandom % 2;
            hx_we     = $urandom % 2;
            hx_addr   = AW'($urandom);
            hx_wdata  = $urandom;
            hx_done   = ($urandom % 5) == 0;
            buf_rdata = $urandom;
            cyc();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule